// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block buffers the receive side of a 16550-style serial port. A deserializer hands it one byte per `rx_valid` pulse, or signals a line break with `rx_break`; the block stores these bytes in a 16-entry first-in first-out queue. It keeps the data-ready, overrun and break status, and it compares the fill level against a trigger level chosen by the FIFO control byte. Software, through the register decoder above this block, drains the queue with `rbr_rd` pulses, and `rd_data` always shows the byte that the next read returns.

A character-timeout timer counts `bit_tick` pulses (one per bit time) against a period of four complete frames. The frame length comes from the line control byte. The timer raises `timeout_pend` when bytes sit unread and no new byte has arrived for that period. When the queue is disabled, the block falls back to a single holding register.

Top module: `uart_rx_queue`

## Requirements
- R1: FCR bits 7:6 choose the trigger level: code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queue mode `trig_hit` is 1 exactly when the level is at or above the trigger. In holding mode `trig_hit` equals data-ready.
- R2: In queue mode (FCR bit 0 = 1), bytes leave in arrival order, up to 16 are held, and `level` shows the count.
- R3: A byte that arrives while the queue is full, with no read in the same cycle, is dropped. It sets `overrun`, and the stored bytes stay intact.
- R4: A byte that arrives in the same cycle as a read of a full queue is treated as a read followed by a store. The byte is kept and `overrun` is not raised.
- R5: A frame has 1 start bit, then LCR[1:0]+5 data bits, then 1 parity bit when LCR[3]=1, then 1 stop bit, or 2 stop bits when LCR[2]=1. The timeout fires on the bit tick that completes four frames after the timer was restarted.
- R6: In queue mode the timer restarts on every received byte or break, and on every read that leaves data behind. On expiry it sets `timeout_pend` only if the queue is not empty.
- R7: Any `rbr_rd` pulse clears `timeout_pend`. Reading an empty queue returns 0. A read that empties the queue clears data-ready and break.
- R8: A break stores a zero byte, subject to the full rule of R3, and sets both `brk` and `data_ready`.
- R9: In holding mode (FCR bit 0 = 0), `level` is 1 while data-ready is set and 0 otherwise. A new byte that arrives while data-ready is set raises `overrun` and replaces the held byte. A read clears data-ready.
- R10: An FCR write with bit 1 set, or one that changes bit 0, empties the queue and clears data-ready, break and the timeout flag.
- R11: The FCR value read back on `fcr_q` is the written byte masked with 0xC9.
- R12: A `status_rd` pulse clears `overrun` and `brk`.
- R13: After reset the queue is empty, all flags are 0 and `fcr_q` is 0, which selects holding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected pulse |
| rbr_rd | input | 1 | Receive buffer read strobe |
| status_rd | input | 1 | Line status read strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| lcr | input | 8 | Line control byte |
| bit_tick | input | 1 | One pulse per bit time |
| rd_data | output | 8 | Byte the next read returns |
| level | output | 5 | Bytes held |
| data_ready | output | 1 | Data available |
| overrun | output | 1 | Overrun status |
| brk | output | 1 | Break status |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |
| fcr_q | output | 8 | Stored FIFO control byte |

## Verification
The collision that matters most is a store and a read landing in the same cycle on a full queue. The bench fills all 16 entries and then asserts `rx_valid` and `rbr_rd` on the same edge. It judges the result by the absence of `overrun`, a level that stays at 16, and the new byte coming out last after the older fifteen. A second collision is between a timer restart and the bit ticks around it: a read that leaves data behind, or a fresh byte, must push expiry a full four frames further out. The bench checks this one tick before expiry and again on the expiring tick.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  // Trigger threshold chosen by the two upper control bits
  function automatic logic [4:0] trig_of(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // Bits per character frame: start + data + optional parity + stop(s)
  function automatic logic [3:0] frame_bits(input logic [7:0] line_ctl);
    logic [3:0] n;
    n = 4'd1 + {2'b00, line_ctl[1:0]} + 4'd5 + {3'b000, line_ctl[3]};
    n = n + (line_ctl[2] ? 4'd2 : 4'd1);
    return n;
  endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop & ~empty & ~clr;
  assign do_push = push & (~full | do_pop) & ~clr;
  assign head    = mem_q[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = bump(wr_q);
      if (do_pop)  rd_n = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end

  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/rxq_timer.sv
`timescale 1ns/1ps
module rxq_timer
  import rxq_pkg::*;
#(
  parameter int FRAMES = 4,
  localparam int CW    = $clog2(FRAMES * 12 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       restart,
  input  logic       bit_tick,
  input  logic       rd_clr,
  input  logic       nonempty,
  input  logic [7:0] line_ctl,
  output logic       pend
);
  logic [CW-1:0] period;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n, pend_q, pend_n;
  logic          expire;

  assign period = CW'(FRAMES * int'(frame_bits(line_ctl)));
  assign expire = run_q & bit_tick & (cnt_q == period - 1'b1);
  assign pend   = pend_q;

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    pend_n = pend_q & ~rd_clr;
    if (clr) begin
      run_n  = 1'b0;
      cnt_n  = '0;
      pend_n = 1'b0;
    end else if (restart) begin
      run_n = 1'b1;
      cnt_n = '0;
    end else if (run_q && bit_tick) begin
      if (expire) begin
        run_n = 1'b0;
        cnt_n = '0;
        if (nonempty && !rd_clr) pend_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(bit_tick && run_q));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> !pend);
endmodule

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TO_FRAMES = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_break,
  input  logic          rbr_rd,
  input  logic          status_rd,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic [7:0]    lcr,
  input  logic          bit_tick,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] level,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk,
  output logic          trig_hit,
  output logic          timeout_pend,
  output logic [7:0]    fcr_q
);
  localparam logic [7:0] FCR_KEEP = 8'hC9;

  logic [7:0]    fcr_r, fcr_n;
  logic [7:0]    hold_q, hold_n;
  logic          hdr_q, hdr_n, ov_q, ov_n, brk_q, brk_n;
  logic          fifo_en, flush, rx_ev;
  logic [7:0]    ev_byte;
  logic          q_push, q_pop, q_full, q_empty;
  logic [7:0]    q_head;
  logic [CW-1:0] q_cnt;
  logic          t_restart, t_clr, ov_set, brk_clr;

  assign fifo_en = fcr_r[0];
  assign flush   = fcr_wr & (fcr_wdata[1] | (fcr_wdata[0] ^ fcr_r[0]));
  assign rx_ev   = rx_valid | rx_break;
  assign ev_byte = rx_break ? 8'h00 : rx_byte;
  assign q_push  = fifo_en & rx_ev;
  assign q_pop   = fifo_en & rbr_rd;

  rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(q_push), .pop(q_pop), .wdata(ev_byte),
    .head(q_head), .count(q_cnt), .full(q_full), .empty(q_empty)
  );

  assign t_restart = (q_push | (q_pop & (q_cnt > CW'(1)))) & ~flush;
  assign t_clr     = flush | ~fifo_en;

  rxq_timer #(.FRAMES(TO_FRAMES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .restart(t_restart),
    .bit_tick(bit_tick), .rd_clr(rbr_rd), .nonempty(~q_empty),
    .line_ctl(lcr), .pend(timeout_pend)
  );

  // Status and holding-register next state
  always_comb begin
    fcr_n  = fcr_r;
    hold_n = hold_q;
    hdr_n  = hdr_q;
    if (fcr_wr) fcr_n = fcr_wdata & FCR_KEEP;

    ov_set = 1'b0;
    if (rx_ev && !flush) begin
      if (fifo_en) ov_set = q_full & ~rbr_rd;
      else         ov_set = hdr_q & ~rbr_rd;
    end

    if (flush) begin
      hdr_n = 1'b0;
    end else if (!fifo_en) begin
      if (rx_ev) begin
        hold_n = ev_byte;
        hdr_n  = 1'b1;
      end else if (rbr_rd) begin
        hdr_n = 1'b0;
      end
    end

    brk_clr = status_rd | flush |
              (rbr_rd & (fifo_en ? (q_cnt <= CW'(1)) : 1'b1));
    brk_n = (rx_break & ~flush) | (brk_q & ~brk_clr);
    ov_n  = ov_set | (ov_q & ~status_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_r  <= '0;
      hold_q <= '0;
      hdr_q  <= 1'b0;
      ov_q   <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      fcr_r  <= fcr_n;
      hold_q <= hold_n;
      hdr_q  <= hdr_n;
      ov_q   <= ov_n;
      brk_q  <= brk_n;
    end
  end

  assign fcr_q      = fcr_r;
  assign overrun    = ov_q;
  assign brk        = brk_q;
  assign data_ready = fifo_en ? ~q_empty : hdr_q;
  assign level      = fifo_en ? q_cnt : CW'(hdr_q);
  assign rd_data    = fifo_en ? (q_empty ? 8'h00 : q_head) : hold_q;
  assign trig_hit   = fifo_en ? (~q_empty & (int'(q_cnt) >= int'(trig_of(fcr_r[7:6]))))
                              : hdr_q;

  // R3
  ov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid || rx_break));
  // R8
  brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> $past(rx_break));
  // R10
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && (fcr_wdata[0] != fcr_q[0])) |=> (level == '0 && !data_ready && !timeout_pend));
endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_break = 1'b0, rbr_rd = 1'b0, status_rd = 1'b0;
  logic       fcr_wr = 1'b0, bit_tick = 1'b0;
  logic [7:0] rx_byte = '0, fcr_wdata = '0, lcr = 8'h03;
  logic [7:0] rd_data, fcr_q;
  logic [4:0] level;
  logic       data_ready, overrun, brk, trig_hit, timeout_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_queue i_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .rbr_rd(rbr_rd), .status_rd(status_rd),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .lcr(lcr), .bit_tick(bit_tick),
    .rd_data(rd_data), .level(level), .data_ready(data_ready),
    .overrun(overrun), .brk(brk), .trig_hit(trig_hit),
    .timeout_pend(timeout_pend), .fcr_q(fcr_q)
  );

  // op: 0 push arg, 1 read expect exp, 2 level expect exp, 3 fcr write arg
  localparam int NV = 19;
  localparam logic [17:0] VEC [NV] = '{
    {2'd3, 8'h01, 8'h00}, {2'd0, 8'hA1, 8'h00}, {2'd2, 8'h00, 8'h01},
    {2'd0, 8'hB2, 8'h00}, {2'd0, 8'hC3, 8'h00}, {2'd2, 8'h00, 8'h03},
    {2'd1, 8'h00, 8'hA1}, {2'd1, 8'h00, 8'hB2}, {2'd2, 8'h00, 8'h01},
    {2'd1, 8'h00, 8'hC3}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h00},
    {2'd3, 8'h81, 8'h00}, {2'd0, 8'h11, 8'h00}, {2'd0, 8'h22, 8'h00},
    {2'd2, 8'h00, 8'h02}, {2'd1, 8'h00, 8'h11}, {2'd1, 8'h00, 8'h22},
    {2'd2, 8'h00, 8'h00}
  };

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; step; rx_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    b = rd_data; rbr_rd = 1'b1; step; rbr_rd = 1'b0;
  endtask

  task automatic wfcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_wdata = v; step; fcr_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step;
    end
    bit_tick = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic to_case(input logic [7:0] l, input int period, input string req);
    logic [7:0] b;
    lcr = l;
    wfcr(8'h03);
    push(8'h40);
    ticks(period - 1);
    chk({req, " before expiry"}, timeout_pend, 0);
    ticks(1);
    chk({req, " at expiry"}, timeout_pend, 1);
    rd(b);
    chk("R7 read clears timeout", timeout_pend, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) step;
    rst_n = 1'b1;
    step;
    // R13 reset state
    chk("R13 level", level, 0);
    chk("R13 data_ready", data_ready, 0);
    chk("R13 flags", {overrun, brk, timeout_pend, trig_hit}, 0);
    chk("R13 fcr", fcr_q, 0);

    // R2 table walk
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][17:16])
        2'd0: push(VEC[v][15:8]);
        2'd1: begin rd(b); chk("R2 table read", b, VEC[v][7:0]); end
        2'd2: chk("R2 table level", level, VEC[v][7:0]);
        default: wfcr(VEC[v][15:8]);
      endcase
    end

    // R11 stored mask
    wfcr(8'hFF);
    chk("R11 fcr mask", fcr_q, 8'hC9);

    // R1 trigger levels
    for (int c = 0; c < 4; c++) begin
      int t;
      t = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      wfcr(8'(c << 6) | 8'h03);
      for (int k = 0; k < t - 1; k++) push(8'(k));
      chk("R1 below trigger", trig_hit, 0);
      push(8'h77);
      chk("R1 at trigger", trig_hit, 1);
    end

    // R3 overrun on full keeps contents
    wfcr(8'h03);
    for (int k = 0; k < 16; k++) push(8'(k));
    chk("R3 full level", level, 16);
    chk("R3 no overrun yet", overrun, 0);
    push(8'hEE);
    chk("R3 overrun set", overrun, 1);
    chk("R3 level kept", level, 16);
    for (int k = 0; k < 16; k++) begin
      rd(b);
      chk("R3 contents kept", b, k);
    end
    // R12 status read
    status_rd = 1'b1; step; status_rd = 1'b0;
    chk("R12 overrun cleared", overrun, 0);

    // R4 push and read on a full queue
    for (int k = 0; k < 16; k++) push(8'(k + 8'h20));
    b = rd_data;
    rx_valid = 1'b1; rx_byte = 8'h5A; rbr_rd = 1'b1; step;
    rx_valid = 1'b0; rbr_rd = 1'b0;
    chk("R4 popped head", b, 8'h20);
    chk("R4 no overrun", overrun, 0);
    chk("R4 level", level, 16);
    for (int k = 0; k < 15; k++) rd(b);
    chk("R4 order before new", b, 8'h2F);
    rd(b);
    chk("R4 new byte last", b, 8'h5A);

    // R5 timeout period for several line settings
    to_case(8'h03, 40, "R5 8N1");
    to_case(8'h00, 28, "R5 5N1");
    to_case(8'h0F, 48, "R5 8P2");

    // R6 read leaving data restarts
    lcr = 8'h03;
    wfcr(8'h03);
    push(8'h01); push(8'h02);
    ticks(20);
    rd(b);
    ticks(39);
    chk("R6 restart on read", timeout_pend, 0);
    ticks(1);
    chk("R6 expiry after read", timeout_pend, 1);
    rd(b);
    // R6 new byte restarts
    push(8'h03);
    ticks(30);
    push(8'h04);
    ticks(39);
    chk("R6 restart on byte", timeout_pend, 0);
    ticks(1);
    chk("R6 expiry after byte", timeout_pend, 1);
    rd(b); rd(b);
    // R6 empty queue gives no flag
    push(8'h05);
    ticks(10);
    rd(b);
    ticks(40);
    chk("R6 empty no flag", timeout_pend, 0);

    // R8 break, R7 emptying read
    rx_break = 1'b1; step; rx_break = 1'b0;
    chk("R8 brk", brk, 1);
    chk("R8 data_ready", data_ready, 1);
    chk("R8 zero byte", rd_data, 0);
    chk("R8 level", level, 1);
    rd(b);
    chk("R7 emptying read clears brk", brk, 0);
    chk("R7 emptying read clears dr", data_ready, 0);
    rd(b);
    chk("R7 empty read returns 0", b, 0);

    // R10 flush by rx reset bit with timeout pending
    push(8'h61);
    ticks(40);
    chk("R10 pend before flush", timeout_pend, 1);
    wfcr(8'h03);
    chk("R10 pend cleared", timeout_pend, 0);
    chk("R10 level cleared", level, 0);
    // R10 flush by enable change
    push(8'h62); push(8'h63);
    wfcr(8'h00);
    chk("R10 mode change level", level, 0);
    chk("R10 mode change dr", data_ready, 0);

    // R9 holding mode
    push(8'h31);
    chk("R9 dr", data_ready, 1);
    chk("R9 level", level, 1);
    chk("R1 holding trig", trig_hit, 1);
    chk("R9 data", rd_data, 8'h31);
    push(8'h32);
    chk("R9 overrun", overrun, 1);
    chk("R9 overwrite", rd_data, 8'h32);
    rd(b);
    chk("R9 read clears dr", data_ready, 0);

    done = 1'b1;
    summary;
  end
endmodule